// File: doc/BRIEF.md
# Quiz Contest Buzzer Arbiter with Answer Window

This block decides who answers first in a quiz round with eight contestant buttons. The host pulses a start input to open an answer window of twelve seconds. While the window is open, the remaining seconds count down on an 8-bit output, one step for each once-per-second enable pulse.

The first contestant whose press reaches the arbiter is latched, and that contestant's number appears on a 4-bit output. From then on every other button is locked out and the countdown freezes. If the window runs out with no press, the countdown rests at zero and an alarm output rises and stays high.

Only the active-low host clear starts a new round. It is sampled on the clock edge and returns the block to idle. Button inputs are taken as already debounced. Each button passes through a two-flop synchronizer before arbitration, so a press takes effect on the third rising clock edge after it appears.

Top module: `buzzer_arbiter`

## Requirements
- R1: While host_clr_n is low at a rising edge, the block returns to idle with winner_id = 0, secs_left = 0 and alarm = 0.
- R2: In idle, a start pulse loads secs_left with 12 on the next edge and opens the answer window.
- R3: While the window is open and no press is accepted, each sec_tick pulse lowers secs_left by exactly one.
- R4: Button bit i (0 to 7) stands for contestant number i+1. The first accepted press drives winner_id to that number, three rising edges after the press appears at the input. winner_id reads 0 while there is no winner.
- R5: When several buttons reach the arbiter in the same cycle, the lowest contestant number wins.
- R6: After a winner is latched, further presses, sec_tick pulses and start pulses change none of the outputs until host_clr_n is asserted.
- R7: When the sec_tick that takes secs_left from 1 to 0 arrives with no press, alarm goes high. winner_id stays 0, secs_left holds at 0 and alarm holds until host_clr_n, and presses are ignored.
- R8: Button presses in idle, before any start, have no effect on the outputs.
- R9: A start pulse while the window is open does not reload the countdown.
- R10: A press that reaches the arbiter in the same cycle as the sec_tick that would end the window wins. The countdown keeps its value and alarm stays low.
- R11: After host_clr_n ends a won or timed-out round, a new start opens a fresh window at 12.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| host_clr_n | input | 1 | Host clear, active low, sampled on the clock edge |
| sec_tick | input | 1 | One-cycle pulse once per second |
| start | input | 1 | Host start pulse, one cycle |
| keys | input | 8 | Contestant buttons, bit i is contestant i+1, active high |
| winner_id | output | 4 | Latched contestant number, 0 when there is no winner |
| secs_left | output | 8 | Seconds remaining in the answer window |
| alarm | output | 1 | Timeout alarm, held until host clear |

## Verification
The assertions assume that host_clr_n is low at the first clock edge. They also assume that sec_tick and start are single-cycle pulses, so the countdown can only fall one step at a time from a nonzero value. The bench holds the clear low for the first two edges and raises every tick and start for exactly one cycle. Buttons may be held for many cycles, because the synchronizer and lockout make the hold length irrelevant. The bench samples each result three edges after a press, which matches the synchronizer depth.

// File: rtl/buzzer_pkg.sv
package buzzer_pkg;

    localparam int KEY_COUNT   = 8;
    localparam int WINDOW_SECS = 12;
    localparam int COUNT_W     = 8;
    localparam int ID_W        = 4;

    typedef enum logic [1:0] {
        RS_IDLE    = 2'd0,
        RS_ARMED   = 2'd1,
        RS_WON     = 2'd2,
        RS_EXPIRED = 2'd3
    } round_state_e;

    // Result of the priority pick over the synchronized buttons.
    typedef struct packed {
        logic            hit;
        logic [ID_W-1:0] num;
    } pick_t;

    // Contestant number for a button index (bit 0 is contestant 1).
    function automatic logic [ID_W-1:0] index_to_num(input int idx);
        return ID_W'(idx + 1);
    endfunction

endpackage

// File: rtl/key_sync.sv
module key_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] synced
);

    logic [WIDTH-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!clr_n) stage_q[0] <= '0;
                    else        stage_q[0] <= raw;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!clr_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign synced = stage_q[STAGES-1];

endmodule

// File: rtl/pick_first.sv
module pick_first
    import buzzer_pkg::*;
#(
    parameter int WIDTH = KEY_COUNT
) (
    input  logic [WIDTH-1:0] req,
    output pick_t            pick
);

    // Scan from the top down so the lowest index is assigned last and wins.
    always_comb begin
        pick.hit = 1'b0;
        pick.num = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            if (req[i]) begin
                pick.hit = 1'b1;
                pick.num = index_to_num(i);
            end
        end
    end

endmodule

// File: rtl/round_fsm.sv
module round_fsm
    import buzzer_pkg::*;
#(
    parameter int WINDOW = WINDOW_SECS,
    parameter int CW     = COUNT_W
) (
    input  logic            clk,
    input  logic            clr_n,
    input  logic            sec_tick,
    input  logic            start,
    input  pick_t           pick,
    output logic [ID_W-1:0] winner,
    output logic [CW-1:0]   count,
    output logic            alarm
);

    localparam logic [CW-1:0] LOAD_VAL = CW'(WINDOW);
    localparam logic [CW-1:0] LAST_SEC = CW'(1);

    round_state_e    st_q, st_d;
    logic [ID_W-1:0] win_q, win_d;
    logic [CW-1:0]   cnt_q, cnt_d;
    logic            alm_q, alm_d;

    always_comb begin
        st_d  = st_q;
        win_d = win_q;
        cnt_d = cnt_q;
        alm_d = alm_q;
        unique case (st_q)
            RS_IDLE: begin
                if (start) begin
                    st_d  = RS_ARMED;
                    cnt_d = LOAD_VAL;
                end
            end
            RS_ARMED: begin
                // A press takes priority over a tick in the same cycle.
                if (pick.hit) begin
                    st_d  = RS_WON;
                    win_d = pick.num;
                end else if (sec_tick) begin
                    cnt_d = cnt_q - LAST_SEC;
                    if (cnt_q <= LAST_SEC) begin
                        st_d  = RS_EXPIRED;
                        cnt_d = '0;
                        alm_d = 1'b1;
                    end
                end
            end
            RS_WON:     ;
            RS_EXPIRED: ;
            default:    st_d = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!clr_n) begin
            st_q  <= RS_IDLE;
            win_q <= '0;
            cnt_q <= '0;
            alm_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            win_q <= win_d;
            cnt_q <= cnt_d;
            alm_q <= alm_d;
        end
    end

    assign winner = win_q;
    assign count  = cnt_q;
    assign alarm  = alm_q;

endmodule

// File: rtl/buzzer_arbiter.sv
module buzzer_arbiter
    import buzzer_pkg::*;
#(
    parameter int NUM_KEYS  = KEY_COUNT,
    parameter int WIN_SECS  = WINDOW_SECS,
    parameter int CNT_W     = COUNT_W,
    parameter int SYNC_DEPTH = 2
) (
    input  logic                clk,
    input  logic                host_clr_n,
    input  logic                sec_tick,
    input  logic                start,
    input  logic [NUM_KEYS-1:0] keys,
    output logic [ID_W-1:0]     winner_id,
    output logic [CNT_W-1:0]    secs_left,
    output logic                alarm
);

    logic [NUM_KEYS-1:0] keys_s;
    pick_t               pick;

    key_sync #(
        .WIDTH (NUM_KEYS),
        .STAGES(SYNC_DEPTH)
    ) u_sync (
        .clk   (clk),
        .clr_n (host_clr_n),
        .raw   (keys),
        .synced(keys_s)
    );

    pick_first #(
        .WIDTH(NUM_KEYS)
    ) u_pick (
        .req (keys_s),
        .pick(pick)
    );

    round_fsm #(
        .WINDOW(WIN_SECS),
        .CW    (CNT_W)
    ) u_fsm (
        .clk     (clk),
        .clr_n   (host_clr_n),
        .sec_tick(sec_tick),
        .start   (start),
        .pick    (pick),
        .winner  (winner_id),
        .count   (secs_left),
        .alarm   (alarm)
    );

endmodule

// File: rtl/buzzer_checker.sv
module buzzer_checker
    import buzzer_pkg::*;
#(
    parameter int NUM_KEYS = KEY_COUNT,
    parameter int WIN_SECS = WINDOW_SECS,
    parameter int CNT_W    = COUNT_W
) (
    input logic            clk,
    input logic            host_clr_n,
    input logic [ID_W-1:0] winner_id,
    input logic [CNT_W-1:0] secs_left,
    input logic            alarm
);

    p_alarm_sticky_r7: assert property (@(posedge clk) disable iff (!host_clr_n)
        alarm |=> alarm);

    p_alarm_clean_r7: assert property (@(posedge clk) disable iff (!host_clr_n)
        alarm |-> (secs_left == '0 && winner_id == '0));

    p_winner_hold_r6: assert property (@(posedge clk) disable iff (!host_clr_n)
        (winner_id != '0) |=> (winner_id == $past(winner_id) && $stable(secs_left)));

    p_winner_range_r4: assert property (@(posedge clk) disable iff (!host_clr_n)
        winner_id <= ID_W'(NUM_KEYS));

    p_count_limit_r2: assert property (@(posedge clk) disable iff (!host_clr_n)
        secs_left <= CNT_W'(WIN_SECS));

    p_count_step_r3: assert property (@(posedge clk) disable iff (!host_clr_n)
        ($past(host_clr_n) && $past(secs_left) != '0 && secs_left != $past(secs_left))
        |-> (secs_left == $past(secs_left) - CNT_W'(1)));

endmodule

bind buzzer_arbiter buzzer_checker #(
    .NUM_KEYS(NUM_KEYS),
    .WIN_SECS(WIN_SECS),
    .CNT_W   (CNT_W)
) u_chk (
    .clk       (clk),
    .host_clr_n(host_clr_n),
    .winner_id (winner_id),
    .secs_left (secs_left),
    .alarm     (alarm)
);

// File: tb/tb_buzzer_arbiter.sv
module tb_buzzer_arbiter;

    logic       clk = 1'b0;
    logic       host_clr_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic       start = 1'b0;
    logic [7:0] keys = '0;
    logic [3:0] winner_id;
    logic [7:0] secs_left;
    logic       alarm;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    typedef struct {
        string      tag;
        logic [3:0] win;
        logic [7:0] cnt;
        logic       alm;
    } exp_t;

    exp_t sb_q[$];

    always #4 clk = ~clk;

    buzzer_arbiter dut (
        .clk       (clk),
        .host_clr_n(host_clr_n),
        .sec_tick  (sec_tick),
        .start     (start),
        .keys      (keys),
        .winner_id (winner_id),
        .secs_left (secs_left),
        .alarm     (alarm)
    );

    // Monitor: compares queued expectations on the falling edge.
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                total++;
                if (winner_id !== e.win || secs_left !== e.cnt || alarm !== e.alm) begin
                    bad++;
                    $display("FAIL %s: got win=%0d cnt=%0d alm=%0b, want win=%0d cnt=%0d alm=%0b",
                             e.tag, winner_id, secs_left, alarm, e.win, e.cnt, e.alm);
                end
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic expect_out(input string tag, input int w, input int c, input bit a);
        exp_t e;
        e.tag = tag;
        e.win = 4'(w);
        e.cnt = 8'(c);
        e.alm = a;
        sb_q.push_back(e);
    endtask

    task automatic do_clear();
        host_clr_n = 1'b0;
        step(1);
        host_clr_n = 1'b1;
    endtask

    task automatic do_start();
        start = 1'b1;
        step(1);
        start = 1'b0;
    endtask

    task automatic do_tick();
        sec_tick = 1'b1;
        step(1);
        sec_tick = 1'b0;
    endtask

    initial begin
        step(2);
        host_clr_n = 1'b1;
        expect_out("R1 reset state", 0, 0, 0);
        step(1);

        // R8: presses in idle do nothing
        keys = 8'h04;
        step(4);
        expect_out("R8 idle press ignored", 0, 0, 0);
        keys = '0;
        step(3);

        // R2: start loads 12
        do_start();
        expect_out("R2 start loads window", 0, 12, 0);
        step(1);

        // R3: ticks decrement
        for (int i = 1; i <= 3; i++) begin
            do_tick();
            expect_out("R3 tick decrement", 0, 12 - i, 0);
            step(1);
        end

        // R9: start while armed does not reload
        do_start();
        expect_out("R9 start ignored while armed", 0, 9, 0);
        step(1);

        // R4: bit 4 is contestant 5
        keys = 8'h10;
        step(3);
        expect_out("R4 first press latched", 5, 9, 0);
        keys = '0;
        step(1);

        // R6: lockout after winner
        keys = 8'h01;
        do_tick();
        do_start();
        step(4);
        expect_out("R6 lockout holds", 5, 9, 0);
        keys = '0;
        step(3);

        // R11 / R1: clear then new round
        do_clear();
        expect_out("R1 clear after win", 0, 0, 0);
        step(1);
        do_start();
        expect_out("R11 fresh window after win", 0, 12, 0);
        step(1);

        // R5: simultaneous presses, lowest number wins
        keys = 8'h44;
        step(3);
        expect_out("R5 lowest wins", 3, 12, 0);
        keys = '0;
        step(2);

        // R7: timeout
        do_clear();
        do_start();
        for (int i = 1; i <= 11; i++) begin
            do_tick();
            step(1);
        end
        expect_out("R7 one second left", 0, 1, 0);
        step(1);
        do_tick();
        expect_out("R7 timeout alarm", 0, 0, 1);
        step(1);
        keys = 8'h02;
        do_tick();
        do_start();
        step(4);
        expect_out("R7 alarm held, press ignored", 0, 0, 1);
        keys = '0;
        step(2);

        do_clear();
        expect_out("R1 clear after timeout", 0, 0, 0);
        step(1);
        do_start();
        expect_out("R11 fresh window after timeout", 0, 12, 0);
        step(1);

        // R10: press and final tick in the same cycle
        for (int i = 1; i <= 11; i++) begin
            do_tick();
            step(1);
        end
        keys = 8'h80;
        step(2);
        do_tick();
        expect_out("R10 press beats final tick", 8, 1, 0);
        keys = '0;
        step(3);
        expect_out("R10 no late alarm", 8, 1, 0);

        step(3);
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: got hung run, want completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule